// File: doc/BRIEF.md
# Programmable Dual-Modulus Prescaler

This block divides a fast input clock by P or by P+1. A two-bit select sets P to 8, 16, 32 or 64. A modulus-control line picks between the two ratios one division cycle at a time. Because the divisor can change every cycle, a slower counter pair outside the block can build large, finely stepped overall ratios by counting the block's output cycles and setting the modulus line.

Internally, a synchronous counter that divides by 4 or by 5 drives a chain of one to four binary divide-by-two stages. The core divides by 5 at most once per division cycle. It does so only in the final core pass, when every active binary stage is at its terminal state and the sampled modulus asks for P+1. The output is a one-clock tick that marks the last input cycle of each division cycle. The select and the modulus line are captured only on the clock edge that ends a division cycle.

Top module: `dmod_prescaler`

## Requirements
- R1: With the sampled modulus low, each division cycle lasts exactly P input clocks, where p_sel 2'b00 gives P=8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64.
- R2: With the sampled modulus high (mod_hi = 1), each division cycle lasts exactly P+1 input clocks for every p_sel value.
- R3: mod_hi is sampled only on the rising edge at which tick is high. The sampled value sets the length of the division cycle that starts after that edge. Changes to mod_hi at any other edge do not change any cycle length.
- R4: The ratio may switch between P and P+1 on consecutive division cycles in any sequence, and every cycle keeps its exact length.
- R5: tick is high for exactly one input clock per division cycle and is never high on two clocks in a row.
- R6: While the synchronous reset rst is high, tick is low and all stages are cleared. mod_hi and p_sel are captured at the reset edge. The first tick after release comes on the (L-1)-th rising edge with rst low, where L = P+mod_hi as captured, so the first cycle has full length counted from the last reset edge.
- R7: p_sel is sampled only on the rising edge at which tick is high (or during reset), and it takes effect from the next division cycle. Changes at other edges have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| p_sel | input | 2 | Prescaler select: 00=8, 01=16, 10=32, 11=64 |
| mod_hi | input | 1 | Modulus control: 1 requests P+1, 0 requests P |
| tick | output | 1 | One-clock pulse in the last input cycle of each division cycle |

## Verification
Any fault in the core, the binary chain or the latched controls shows up at the port as a wrong gap between two ticks. It is therefore seen by the end of the division cycle in which it happens, at most 65 clocks later. A swallow that fires at the wrong time, or fails to fire, moves the gap by exactly one clock. A wrong stage count for a select doubles or halves the gap. The bench changes the control inputs between terminal edges, so a control captured at the wrong edge gives a gap that differs from the expected one.

// File: rtl/dmp_pkg.sv
package dmp_pkg;
    localparam int CORE_W = 3;
    localparam logic [CORE_W-1:0] CORE_END4 = 3'd3;
    localparam logic [CORE_W-1:0] CORE_END5 = 3'd4;
    localparam int CORE_BASE = 4;
endpackage

// File: rtl/dmp_core45.sv
module dmp_core45
    import dmp_pkg::*;
(
    input  logic [CORE_W-1:0] core_q,
    input  logic              swallow,
    output logic [CORE_W-1:0] core_d,
    output logic              wrap
);
    logic [CORE_W-1:0] end_val;

    always_comb begin
        end_val = swallow ? CORE_END5 : CORE_END4;
        wrap    = (core_q == end_val);
        core_d  = wrap ? '0 : CORE_W'(core_q + 1'b1);
    end
endmodule

// File: rtl/dmp_bin_chain.sv
module dmp_bin_chain #(
    parameter int N_STAGES = 4,
    parameter int SEL_W    = 2
) (
    input  logic [N_STAGES-1:0] bin_q,
    input  logic [SEL_W-1:0]    psel,
    input  logic                adv,
    output logic [N_STAGES-1:0] bin_d,
    output logic                term
);
    logic [N_STAGES-1:0] active;

    for (genvar i = 0; i < N_STAGES; i++) begin : g_stage_en
        assign active[i] = (i <= int'(psel));
    end

    always_comb begin
        logic carry;
        carry = adv;
        for (int i = 0; i < N_STAGES; i++) begin
            bin_d[i] = active[i] ? (bin_q[i] ^ carry) : 1'b0;
            carry    = carry & bin_q[i];
        end
        term = &(bin_q | ~active);
    end
endmodule

// File: rtl/dmod_prescaler.sv
module dmod_prescaler
    import dmp_pkg::*;
#(
    parameter int N_STAGES = 4,
    localparam int SEL_W = (N_STAGES > 1) ? $clog2(N_STAGES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] p_sel,
    input  logic             mod_hi,
    output logic             tick
);
    typedef struct packed {
        logic [CORE_W-1:0]   core;
        logic [N_STAGES-1:0] bin;
        logic                mod;
        logic [SEL_W-1:0]    psel;
    } state_t;

    state_t state_q, state_d;

    logic [CORE_W-1:0]   core_nx;
    logic [N_STAGES-1:0] bin_nx;
    logic                core_wrap;
    logic                bin_term;
    logic                swallow;

    assign swallow = state_q.mod & bin_term;

    dmp_core45 u_core (
        .core_q  (state_q.core),
        .swallow (swallow),
        .core_d  (core_nx),
        .wrap    (core_wrap)
    );

    dmp_bin_chain #(
        .N_STAGES (N_STAGES),
        .SEL_W    (SEL_W)
    ) u_chain (
        .bin_q (state_q.bin),
        .psel  (state_q.psel),
        .adv   (core_wrap),
        .bin_d (bin_nx),
        .term  (bin_term)
    );

    always_comb begin
        state_d      = state_q;
        state_d.core = core_nx;
        state_d.bin  = bin_nx;
        if (core_wrap && bin_term) begin
            state_d.mod  = mod_hi;
            state_d.psel = p_sel;
        end
    end

    assign tick = core_wrap & bin_term;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.core <= '0;
            state_q.bin  <= '0;
            state_q.mod  <= mod_hi;
            state_q.psel <= p_sel;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/dmp_checker.sv
module dmp_checker #(
    parameter int N_STAGES = 4,
    parameter int SEL_W    = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                tick,
    input logic                mod_hi,
    input logic [2:0]          core_q,
    input logic [N_STAGES-1:0] bin_q,
    input logic                mod_q,
    input logic [SEL_W-1:0]    psel_q
);
    logic [N_STAGES-1:0] live;
    always_comb begin
        for (int i = 0; i < N_STAGES; i++) live[i] = (i <= int'(psel_q));
    end

    a_r5_tick_single: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    a_r2_core_bound: assert property (@(posedge clk) disable iff (rst)
        core_q <= 3'd4);

    a_r2_swallow_only_last: assert property (@(posedge clk) disable iff (rst)
        (core_q == 3'd4) |-> (mod_q && ((bin_q | ~live) == '1)));

    a_r3_mod_held: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(mod_q));

    a_r3_mod_capture: assert property (@(posedge clk) disable iff (rst)
        tick |=> (mod_q == $past(mod_hi)));

    a_r7_psel_held: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(psel_q));

    a_r1_idle_stages_zero: assert property (@(posedge clk) disable iff (rst)
        (bin_q & ~live) == '0);

    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (core_q == 3'd0 && bin_q == '0));
endmodule

bind dmod_prescaler dmp_checker #(
    .N_STAGES (N_STAGES),
    .SEL_W    (SEL_W)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .mod_hi (mod_hi),
    .core_q (state_q.core),
    .bin_q  (state_q.bin),
    .mod_q  (state_q.mod),
    .psel_q (state_q.psel)
);

// File: tb/dmod_prescaler_bench.sv
`timescale 1ns/1ps
module dmod_prescaler_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] p_sel = 2'b00;
    logic       mod_hi = 1'b0;
    logic       tick;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    bit         garble = 1'b0;
    logic       prev_tick = 1'b0;
    int         seed_sink;

    always #2.5 clk = ~clk;

    dmod_prescaler u_dmod_prescaler (
        .clk    (clk),
        .rst    (rst),
        .p_sel  (p_sel),
        .mod_hi (mod_hi),
        .tick   (tick)
    );

    function automatic int exp_len(logic [1:0] s, logic m);
        return (8 << s) + int'(m);
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R5 monitor: no two consecutive ticks
    always @(negedge clk) begin
        if (!rst && tick) check(!prev_tick, "R5 tick width", 2, 1);
        prev_tick <= rst ? 1'b0 : tick;
    end

    task automatic count_edges(output int n);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (!tick && garble) begin
                p_sel  = 2'($urandom);
                mod_hi = 1'($urandom);
            end
        end while (!tick && n < 300);
    endtask

    task automatic do_reset(logic [1:0] s, logic m);
        int n;
        @(negedge clk);
        rst = 1'b1;
        p_sel = s;
        mod_hi = m;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(tick == 1'b0, "R6 tick low in reset", int'(tick), 0);
        end
        rst = 1'b0;
        count_edges(n);
        check(n == exp_len(s, m) - 1, "R6 first cycle length", n, exp_len(s, m) - 1);
    endtask

    task automatic run(logic [1:0] s, logic m, string req);
        int n;
        p_sel = s;
        mod_hi = m;
        count_edges(n);
        check(n == exp_len(s, m), req, n, exp_len(s, m));
    endtask

    initial begin
        seed_sink = $urandom(32'h5A17);
        do_reset(2'b00, 1'b0);
        for (int s = 0; s < 4; s++) begin
            for (int m = 0; m < 2; m++) begin
                run(2'(s), 1'(m), (m == 0) ? "R1 divide by P" : "R2 divide by P+1");
                run(2'(s), 1'(m), (m == 0) ? "R1 divide by P" : "R2 divide by P+1");
            end
        end
        for (int s = 0; s < 4; s++) begin
            for (int k = 0; k < 6; k++) run(2'(s), 1'(k % 2), "R4 alternate modulus");
            run(2'(s), 1'b1, "R4 repeat high");
            run(2'(s), 1'b1, "R4 repeat high");
            run(2'(s), 1'b0, "R4 back to low");
        end
        garble = 1'b1;
        for (int k = 0; k < 40; k++) run(2'($urandom), 1'($urandom), "R3 R7 mid-cycle changes ignored");
        garble = 1'b0;
        do_reset(2'b11, 1'b1);
        do_reset(2'b01, 1'b1);
        run(2'b10, 1'b0, "R7 select switch after reset");
        for (int k = 0; k < 200; k++) begin
            garble = 1'($urandom);
            run(2'($urandom), 1'($urandom), "R4 random sequence");
        end
        garble = 1'b0;
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule